// File: doc/BRIEF.md
# Chip-Select Address Region Decoder

This block sits between a system address bus and a set of external memory chip selects. It compares each access address against a number of programmable regions. Each region has a 6-bit base that lines up with address bits [29:24], a 4-bit size mask over bits [27:24], and a valid flag. When a valid region matches, the block raises that region's one-hot select line. It also reports the in-region offset and routes the access to one of three back ends: a direct memory port, a NAND command/data port, or a prefetch FIFO port. The FIFO port is chosen only when the prefetch engine is enabled and aimed at the selected region.

Each region has one configuration word. Software writes it through a simple indexed write port and reads it back through an indexed read port. A region's device type comes from a static input per region. The prefetch engine's enable and target region come in as plain inputs. Decode and routing are combinational. Configuration writes take effect on the next clock edge.

Top module: `cs_region_decoder`

## Requirements
- R1: A configuration word holds the base in bits [5:0], the valid flag in bit 6 and the mask code in bits [11:8]; a write stores only the bits under 0xF7F (bit 7 always reads back 0), and the stored word is returned on `cfg_rdata` for the region named by `cfg_rsel` from the edge after the write.
- R2: After reset, every region reads back mask 0xF and base 0; region 0 reads 0xF40 (valid), all others read 0xF00 (invalid), and `mask_err` is 0.
- R3: A region whose valid bit is 0 never raises its select line, whatever the address.
- R4: A valid region matches when address bits [29:28] equal base bits [5:4] and, for every bit set in the mask code, address bit [24+k] equals base bit k; codes 0xF, 0xE, 0xC and 0x8 give regions of 16, 32, 64 and 128 MB.
- R5: Mask code 0 (256 MB, bits [27:24] all ignored) is legal only when parameter `ALLOW_FULL_MASK` is 1; with the default value 0 it is illegal.
- R6: A configuration write whose mask code is illegal sets `mask_err` from the following cycle on, and it stays set until reset. A region holding an illegal code decodes as 16 MB, yet its stored code still reads back unchanged.
- R7: When several valid regions match, only the lowest-numbered one is selected and `overlap_err` is 1 in that cycle; with exactly one match `overlap_err` is 0.
- R8: For a selected region, device type 0 (bits [2i+1:2i] of `region_kind`) routes to `to_mem`. Any other type routes to `to_fifo` when `pf_enable` is 1 and `pf_cs` equals the region number, and to `to_nand` otherwise. Exactly one route is high on a hit.
- R9: With `acc_valid` low or no matching region, `cs_sel`, `acc_hit`, all route outputs, `overlap_err` and `acc_offset` are 0.
- R10: On a hit, `acc_offset` equals address bits [27:0] with bits [27:24] cleared wherever the region's effective mask has a 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | IDX_W | Region written |
| cfg_wdata | input | 12 | Configuration write data |
| cfg_rsel | input | IDX_W | Region read back |
| cfg_rdata | output | 12 | Stored configuration of region `cfg_rsel` |
| region_kind | input | 2*NUM_CS | Device type per region, 0 = direct memory |
| pf_enable | input | 1 | Prefetch engine enabled |
| pf_cs | input | IDX_W | Region served by the prefetch engine |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 30 | Access address |
| cs_sel | output | NUM_CS | One-hot chip select |
| acc_hit | output | 1 | Some valid region matched |
| to_mem | output | 1 | Route to direct memory port |
| to_nand | output | 1 | Route to NAND access port |
| to_fifo | output | 1 | Route to prefetch FIFO port |
| acc_offset | output | 28 | Offset inside the selected region |
| overlap_err | output | 1 | More than one valid region matched |
| mask_err | output | 1 | Sticky: an illegal mask code was written |

## Verification
The assertions assume that `cfg_sel`, `cfg_rsel` and `pf_cs` name existing regions. They also assume that `region_kind`, `pf_enable`, `pf_cs` and the access inputs stay stable around each rising edge, since the decode paths are combinational and are sampled there. The bench changes every input only on the falling clock edge, keeps every region index below the region count, and samples outputs one time unit after the inputs change.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
   localparam int BASE_W   = 6;
   localparam int MASK_W   = 4;
   localparam int CFG_W    = 12;
   localparam int SYS_AW   = 30;
   localparam int PAGE_LSB = 24;
   localparam int OFS_W    = 28;
   localparam logic [CFG_W-1:0] CFG_KEEP = 12'hF7F;

   typedef struct packed {
      logic [MASK_W-1:0] mask;
      logic              spare;
      logic              valid;
      logic [BASE_W-1:0] base;
   } region_cfg_t;

   typedef enum logic [1:0] {RT_NONE, RT_MEM, RT_NAND, RT_FIFO} route_e;

   function automatic logic mask_code_ok(input logic [MASK_W-1:0] m, input logic allow_full);
      case (m)
         4'hF, 4'hE, 4'hC, 4'h8: mask_code_ok = 1'b1;
         4'h0:                   mask_code_ok = allow_full;
         default:                mask_code_ok = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/cs_region_reg.sv
module cs_region_reg
   import cs_dec_pkg::*;
#(
   parameter bit RESET_VALID     = 1'b0,
   parameter bit ALLOW_FULL_MASK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CFG_W-1:0]  wr_data,
   output region_cfg_t       cfg_q,
   output logic [MASK_W-1:0] eff_mask,
   output logic              bad_write
);
   region_cfg_t wr_cfg;
   logic        held_ok;
   logic        new_ok;

   assign wr_cfg = region_cfg_t'(wr_data & CFG_KEEP);

   generate
      if (ALLOW_FULL_MASK) begin : g_full
         assign held_ok = mask_code_ok(cfg_q.mask, 1'b1);
         assign new_ok  = mask_code_ok(wr_cfg.mask, 1'b1);
      end else begin : g_strict
         assign held_ok = mask_code_ok(cfg_q.mask, 1'b0);
         assign new_ok  = mask_code_ok(wr_cfg.mask, 1'b0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.mask  <= '1;
         cfg_q.spare <= 1'b0;
         cfg_q.valid <= RESET_VALID;
         cfg_q.base  <= '0;
      end else if (wr_en) begin
         cfg_q <= wr_cfg;
      end
   end

   assign eff_mask  = held_ok ? cfg_q.mask : '1;
   assign bad_write = wr_en & ~new_ok;

   // R1
   spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !cfg_q.spare);
   // R6
   eff_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.mask != eff_mask) |-> (eff_mask == 4'hF));
endmodule

// File: rtl/cs_region_match.sv
module cs_region_match
   import cs_dec_pkg::*;
(
   input  region_cfg_t       cfg,
   input  logic [MASK_W-1:0] eff_mask,
   input  logic [SYS_AW-1:0] addr,
   output logic              hit
);
   logic [BASE_W-1:0] cmp_en;
   logic [BASE_W-1:0] diff;

   assign cmp_en = {2'b11, eff_mask};
   assign diff   = addr[SYS_AW-1:PAGE_LSB] ^ cfg.base;
   assign hit    = cfg.valid && ((diff & cmp_en) == '0);
endmodule

// File: rtl/cs_priority_pick.sv
module cs_priority_pick #(
   parameter int N = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any,
   output logic             multi
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any   = |req;
   assign multi = |(req & (req - N'(1)));
   assign grant = any ? (N'(1) << idx) : '0;
endmodule

// File: rtl/cs_route.sv
module cs_route
   import cs_dec_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             any,
   input  logic [IDX_W-1:0] idx,
   input  logic [1:0]       kind,
   input  logic             pf_en,
   input  logic [IDX_W-1:0] pf_cs,
   output route_e           route
);
   always_comb begin
      route = RT_NONE;
      if (any) begin
         if (kind == 2'd0)                  route = RT_MEM;
         else if (pf_en && (pf_cs == idx)) route = RT_FIFO;
         else                               route = RT_NAND;
      end
   end
endmodule

// File: rtl/cs_region_decoder.sv
module cs_region_decoder
   import cs_dec_pkg::*;
#(
   parameter int NUM_CS          = 8,
   parameter bit ALLOW_FULL_MASK = 1'b0,
   localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [IDX_W-1:0]      cfg_sel,
   input  logic [CFG_W-1:0]      cfg_wdata,
   input  logic [IDX_W-1:0]      cfg_rsel,
   output logic [CFG_W-1:0]      cfg_rdata,
   input  logic [2*NUM_CS-1:0]   region_kind,
   input  logic                  pf_enable,
   input  logic [IDX_W-1:0]      pf_cs,
   input  logic                  acc_valid,
   input  logic [SYS_AW-1:0]     acc_addr,
   output logic [NUM_CS-1:0]     cs_sel,
   output logic                  acc_hit,
   output logic                  to_mem,
   output logic                  to_nand,
   output logic                  to_fifo,
   output logic [OFS_W-1:0]      acc_offset,
   output logic                  overlap_err,
   output logic                  mask_err
);
   localparam logic [IDX_W:0] NCS_L = NUM_CS[IDX_W:0];

   generate
      if (NUM_CS < 2 || NUM_CS > 64) begin : g_bad_count
         $error("cs_region_decoder: NUM_CS must lie in 2..64");
      end
   endgenerate

   region_cfg_t       rcfg   [NUM_CS];
   logic [MASK_W-1:0] reff   [NUM_CS];
   logic [1:0]        rkind  [NUM_CS];
   logic [NUM_CS-1:0] rhit;
   logic [NUM_CS-1:0] rbad;
   logic [NUM_CS-1:0] req;
   logic [NUM_CS-1:0] grant;
   logic [IDX_W-1:0]  pick;
   logic              any;
   logic              multi;
   route_e            route;
   logic              mask_err_q;

   generate
      for (genvar i = 0; i < NUM_CS; i++) begin : g_region
         localparam logic [IDX_W-1:0] MY_ID = IDX_W'(i);
         cs_region_reg #(
            .RESET_VALID     (i == 0),
            .ALLOW_FULL_MASK (ALLOW_FULL_MASK)
         ) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_we && (cfg_sel == MY_ID)),
            .wr_data   (cfg_wdata),
            .cfg_q     (rcfg[i]),
            .eff_mask  (reff[i]),
            .bad_write (rbad[i])
         );
         cs_region_match u_match (
            .cfg      (rcfg[i]),
            .eff_mask (reff[i]),
            .addr     (acc_addr),
            .hit      (rhit[i])
         );
         assign rkind[i] = region_kind[2*i +: 2];

         // R3
         invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cs_sel[i] |-> rcfg[i].valid);
      end
   endgenerate

   assign req = acc_valid ? rhit : '0;

   cs_priority_pick #(.N(NUM_CS)) u_pick (
      .req   (req),
      .grant (grant),
      .idx   (pick),
      .any   (any),
      .multi (multi)
   );

   cs_route #(.IDX_W(IDX_W)) u_route (
      .any   (any),
      .idx   (pick),
      .kind  (rkind[pick]),
      .pf_en (pf_enable),
      .pf_cs (pf_cs),
      .route (route)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_err_q <= 1'b0;
      else if (|rbad) mask_err_q <= 1'b1;
   end

   assign cs_sel      = grant;
   assign acc_hit     = any;
   assign overlap_err = multi;
   assign to_mem      = (route == RT_MEM);
   assign to_nand     = (route == RT_NAND);
   assign to_fifo     = (route == RT_FIFO);
   assign acc_offset  = any ? (acc_addr[OFS_W-1:0] & ~{reff[pick], {PAGE_LSB{1'b0}}}) : '0;
   assign mask_err    = mask_err_q;
   assign cfg_rdata   = ({1'b0, cfg_rsel} < NCS_L) ? CFG_W'(rcfg[cfg_rsel]) : '0;

   // R7
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_sel));
   // R8
   one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({to_mem, to_nand, to_fifo}) == (acc_hit ? 1 : 0));
   // R8
   fifo_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      to_fifo |-> (pf_enable && cs_sel[pf_cs]));
   // R6
   mask_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_err |=> mask_err);
   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (cs_sel == '0 && !to_mem && !to_nand && !to_fifo && !overlap_err));
   // R10
   miss_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_hit |-> (acc_offset == '0));
endmodule

// File: tb/sim_cs_region_decoder.sv
module sim_cs_region_decoder;
   import cs_dec_pkg::*;

   localparam int NCS = 8;
   localparam int IW  = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [IW-1:0]     cfg_sel = '0;
   logic [CFG_W-1:0]  cfg_wdata = '0;
   logic [IW-1:0]     cfg_rsel = '0;
   logic [CFG_W-1:0]  cfg_rdata;
   logic [2*NCS-1:0]  region_kind = '0;
   logic              pf_enable = 1'b0;
   logic [IW-1:0]     pf_cs = '0;
   logic              acc_valid = 1'b0;
   logic [SYS_AW-1:0] acc_addr = '0;
   logic [NCS-1:0]    cs_sel;
   logic              acc_hit, to_mem, to_nand, to_fifo, overlap_err, mask_err;
   logic [OFS_W-1:0]  acc_offset;

   int checks = 0;
   int errs   = 0;

   always #4 clk = ~clk;

   cs_region_decoder u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata), .region_kind(region_kind),
      .pf_enable(pf_enable), .pf_cs(pf_cs), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .cs_sel(cs_sel), .acc_hit(acc_hit), .to_mem(to_mem), .to_nand(to_nand),
      .to_fifo(to_fifo), .acc_offset(acc_offset), .overlap_err(overlap_err), .mask_err(mask_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic cfg_wr(input int idx, input logic [CFG_W-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = IW'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input int idx);
      cfg_rsel = IW'(idx);
      #1;
   endtask

   task automatic probe(input logic [SYS_AW-1:0] a, input logic v);
      @(negedge clk);
      acc_addr = a; acc_valid = v;
      #1;
   endtask

   task automatic t_reset;
      rd(0); chk("R2 region0 word", 32'(cfg_rdata), 32'hF40);
      rd(3); chk("R2 region3 word", 32'(cfg_rdata), 32'hF00);
      chk("R2 mask_err", 32'(mask_err), 0);
      probe(30'h0012_3456, 1'b1);
      chk("R2 region0 live sel", 32'(cs_sel), 32'h01);
      chk("R10 offset 16MB", 32'(acc_offset), 32'h12_3456);
      chk("R8 direct route", 32'({to_mem, to_nand, to_fifo}), 32'b100);
      probe(30'h0100_0000, 1'b1);
      chk("R9 miss sel", 32'(cs_sel), 0);
      chk("R9 miss hit", 32'(acc_hit), 0);
   endtask

   task automatic t_keep;
      cfg_wr(2, 12'hFFF);
      rd(2); chk("R1 write keep", 32'(cfg_rdata), 32'hF7F);
      probe(30'h3F00_0000, 1'b1);
      chk("R1 base 3F decode", 32'(cs_sel), 32'h04);
      cfg_wr(2, 12'hF00);
      rd(2); chk("R1 rewrite", 32'(cfg_rdata), 32'hF00);
   endtask

   task automatic t_invalid;
      cfg_wr(1, 12'hF05);
      probe(30'h0500_0000, 1'b1);
      chk("R3 invalid no decode", 32'(cs_sel), 0);
      cfg_wr(1, 12'hF45);
      probe(30'h0500_0000, 1'b1);
      chk("R3 now valid", 32'(cs_sel), 32'h02);
   endtask

   task automatic t_sizes;
      cfg_wr(1, 12'hE50);
      probe(30'h1100_0010, 1'b1);
      chk("R4 32MB upper half", 32'(cs_sel), 32'h02);
      chk("R10 offset 32MB", 32'(acc_offset), 32'h100_0010);
      probe(30'h1200_0000, 1'b1);
      chk("R4 32MB outside", 32'(cs_sel), 0);
      cfg_wr(1, 12'hC50);
      probe(30'h1300_0000, 1'b1);
      chk("R4 64MB top", 32'(cs_sel), 32'h02);
      chk("R10 offset 64MB", 32'(acc_offset), 32'h300_0000);
      probe(30'h1400_0000, 1'b1);
      chk("R4 64MB outside", 32'(cs_sel), 0);
      cfg_wr(1, 12'h850);
      probe(30'h1700_0004, 1'b1);
      chk("R4 128MB top", 32'(cs_sel), 32'h02);
      chk("R10 offset 128MB", 32'(acc_offset), 32'h700_0004);
      probe(30'h1800_0000, 1'b1);
      chk("R4 128MB outside", 32'(cs_sel), 0);
      probe(30'h3000_0000, 1'b1);
      chk("R4 bit29 always compared", 32'(cs_sel), 0);
      chk("R6 legal codes leave flag", 32'(mask_err), 0);
   endtask

   task automatic t_illegal;
      cfg_wr(1, 12'h050);
      chk("R5 code 0 illegal by default", 32'(mask_err), 1);
      rd(1); chk("R6 raw code kept", 32'(cfg_rdata), 32'h050);
      probe(30'h10AB_CDEF, 1'b1);
      chk("R6 decoded as 16MB hit", 32'(cs_sel), 32'h02);
      chk("R6 16MB offset", 32'(acc_offset), 32'hAB_CDEF);
      probe(30'h1100_0000, 1'b1);
      chk("R6 decoded as 16MB miss", 32'(cs_sel), 0);
      cfg_wr(1, 12'hF50);
      chk("R6 flag sticky", 32'(mask_err), 1);
   endtask

   task automatic t_overlap;
      cfg_wr(1, 12'hF40);
      probe(30'h0000_0100, 1'b1);
      chk("R7 lowest wins", 32'(cs_sel), 32'h01);
      chk("R7 overlap flag", 32'(overlap_err), 1);
      cfg_wr(1, 12'hF00);
      probe(30'h0000_0100, 1'b1);
      chk("R7 single match", 32'(overlap_err), 0);
      cfg_wr(3, 12'hF48);
      cfg_wr(5, 12'hF48);
      probe(30'h0800_0000, 1'b1);
      chk("R7 3 beats 5", 32'(cs_sel), 32'h08);
      chk("R7 overlap 3/5", 32'(overlap_err), 1);
      cfg_wr(3, 12'hF08);
      probe(30'h0800_0000, 1'b1);
      chk("R7 5 alone", 32'(cs_sel), 32'h20);
      chk("R7 no overlap", 32'(overlap_err), 0);
   endtask

   task automatic t_route;
      @(negedge clk);
      region_kind[11:10] = 2'b10;
      probe(30'h0800_0000, 1'b1);
      chk("R8 nand no prefetch", 32'({to_mem, to_nand, to_fifo}), 32'b010);
      @(negedge clk); pf_enable = 1'b1; pf_cs = 3'd5;
      probe(30'h0800_0000, 1'b1);
      chk("R8 fifo route", 32'({to_mem, to_nand, to_fifo}), 32'b001);
      @(negedge clk); pf_cs = 3'd3;
      probe(30'h0800_0000, 1'b1);
      chk("R8 prefetch elsewhere", 32'({to_mem, to_nand, to_fifo}), 32'b010);
      @(negedge clk); pf_cs = 3'd5; region_kind[11:10] = 2'b00;
      probe(30'h0800_0000, 1'b1);
      chk("R8 direct beats prefetch", 32'({to_mem, to_nand, to_fifo}), 32'b100);
      @(negedge clk); region_kind[11:10] = 2'b01; pf_enable = 1'b0;
      probe(30'h0800_0000, 1'b1);
      chk("R8 prefetch off", 32'({to_mem, to_nand, to_fifo}), 32'b010);
   endtask

   task automatic t_idle;
      @(negedge clk); pf_enable = 1'b1;
      probe(30'h0800_0000, 1'b0);
      chk("R9 idle sel", 32'(cs_sel), 0);
      chk("R9 idle hit", 32'(acc_hit), 0);
      chk("R9 idle routes", 32'({to_mem, to_nand, to_fifo}), 0);
      chk("R9 idle offset", 32'(acc_offset), 0);
   endtask

   initial begin
      #(8 * 100000);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #20 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_keep();
      t_invalid();
      t_sizes();
      t_illegal();
      t_overlap();
      t_route();
      t_idle();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule